// File: doc/BRIEF.md
# Single-Cycle Nine-Instruction Processor Core

This block is a 32-bit processor core that finishes every instruction in one clock cycle. It supports a small instruction subset:

- word load and word store;
- register-to-register add, subtract, AND, OR and signed set-less-than;
- branch-if-equal and unconditional jump.

Inside the block are a 32-entry register file, a main decoder, an ALU-operation decoder, the ALU, an immediate sign extender and the next-PC selection. A word-wide instruction store and a separate word-wide data store also sit inside the block.

A test harness uses the block as follows:

1. It holds reset and preloads both stores through a plain write port.
2. It releases reset and lets the program run.
3. It reads any register and any data word through two combinational inspection ports.

The current PC is visible at all times.

All preload, inspection and PC pins are plain control and status signals. The block has no streaming data interface, so there is no valid/ready handshake and no back-pressure. Every instruction issued is retired in the same cycle.

Top module: `scp_core`

## Requirements
- R1: While `rst` is high at a rising edge, the PC becomes 0 at that edge. No register-file or data-store write from the executing instruction takes place during reset.
- R2: Every instruction except a taken branch or a jump advances the PC by 4. The instruction store is indexed by PC bits [7:2].
- R3: A load has opcode 0x23, with rs in bits [25:21], rt in bits [20:16] and a 16-bit offset in bits [15:0]. It reads the data word at rs + sign-extended offset and writes it to rt. The data store is indexed by address bits [7:2], and negative offsets work.
- R4: A store has opcode 0x2B. It writes the rt value to the data word at rs + sign-extended offset. It writes no register, including the register named by bits [15:11].
- R5: A register-type instruction has opcode 0x00 and writes register rd (bits [15:11]). The funct field in bits [5:0] selects the operation: 0x20 add, 0x22 subtract (rs − rt), 0x24 AND, 0x25 OR.
- R6: Funct 0x2A (set-less-than) writes 1 when rs < rt as signed 32-bit values and 0 otherwise.
- R7: A branch-if-equal has opcode 0x04. When rs equals rt, the next PC is PC + 4 + (sign-extended offset × 4). Otherwise the next PC is PC + 4.
- R8: A jump has opcode 0x02. The next PC is {PC+4 bits [31:28], instruction bits [25:0], 2'b00}.
- R9: Register 0 always reads as 0, and any write to it is discarded.
- R10: The preload strobes `ld_imem_we` and `ld_dmem_we` write `ld_data` at word `ld_addr` only while `rst` is high. They have no effect while the core runs.
- R11: `dbg_reg_val` and `dbg_mem_val` follow their select inputs combinationally. A write made at a rising edge is visible on them right after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state updates on the rising edge |
| rst | input | 1 | Synchronous active-high reset; also opens the preload port |
| ld_imem_we | input | 1 | Preload strobe for the instruction store |
| ld_dmem_we | input | 1 | Preload strobe for the data store |
| ld_addr | input | LD_AW (6) | Word index for a preload write |
| ld_data | input | 32 | Word written by a preload |
| dbg_reg_sel | input | 5 | Register number to inspect |
| dbg_reg_val | output | 32 | Value of the selected register |
| dbg_mem_addr | input | DMEM_AW (6) | Data word index to inspect |
| dbg_mem_val | output | 32 | Value of the selected data word |
| pc_out | output | 32 | Current program counter |

## Verification
An instruction executes during the cycle its PC is current, and its register or data write lands at the rising edge that ends that cycle. That same edge loads the next PC, so `pc_out` and both inspection ports show the result one edge after the instruction became current. The bench drives every input and samples every output on the falling edge. It releases reset on a falling edge and then compares `pc_out` after each later falling edge against a PC trace worked out by hand from the program. Register and data results are read after the program has settled into a self-jump, so their timing cannot alias. The reset and preload-blocking checks look at the data store and the PC several cycles after the attempted write.

// File: rtl/scp_pkg.sv
package scp_pkg;
  localparam int XLEN = 32;

  localparam logic [5:0] OPC_RTYPE = 6'h00;
  localparam logic [5:0] OPC_LOAD  = 6'h23;
  localparam logic [5:0] OPC_STORE = 6'h2B;
  localparam logic [5:0] OPC_BEQ   = 6'h04;
  localparam logic [5:0] OPC_JUMP  = 6'h02;

  localparam logic [5:0] FN_ADD = 6'h20;
  localparam logic [5:0] FN_SUB = 6'h22;
  localparam logic [5:0] FN_AND = 6'h24;
  localparam logic [5:0] FN_OR  = 6'h25;
  localparam logic [5:0] FN_SLT = 6'h2A;

  typedef enum logic [1:0] {
    AGRP_ADD   = 2'b00,
    AGRP_SUB   = 2'b01,
    AGRP_FUNCT = 2'b10
  } alu_grp_e;

  typedef enum logic [2:0] {
    ALU_AND = 3'd0,
    ALU_OR  = 3'd1,
    ALU_ADD = 3'd2,
    ALU_SUB = 3'd3,
    ALU_SLT = 3'd4
  } alu_sel_e;

  typedef struct packed {
    logic     dst_from_rd;
    logic     b_from_imm;
    logic     wb_from_mem;
    logic     rf_write;
    logic     dm_read;
    logic     dm_write;
    logic     is_branch;
    logic     is_jump;
    alu_grp_e grp;
  } ctl_t;
endpackage

// File: rtl/scp_alu.sv
module scp_alu
  import scp_pkg::*;
#(
  parameter int W = XLEN
) (
  input  alu_sel_e     sel,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] y,
  output logic         zero
);
  logic [W-1:0] diff;
  logic         lt_signed;

  assign diff      = a - b;
  assign lt_signed = (a[W-1] != b[W-1]) ? a[W-1] : diff[W-1];

  always_comb begin
    unique case (sel)
      ALU_AND: y = a & b;
      ALU_OR:  y = a | b;
      ALU_ADD: y = a + b;
      ALU_SUB: y = diff;
      ALU_SLT: y = {{(W-1){1'b0}}, lt_signed};
      default: y = a + b;
    endcase
  end

  assign zero = (y == '0);
endmodule

// File: rtl/scp_ctrl.sv
module scp_ctrl
  import scp_pkg::*;
(
  input  logic [5:0] opcode,
  input  logic [5:0] funct,
  output ctl_t       ctl,
  output alu_sel_e   alu_sel
);
  always_comb begin
    ctl = '0;
    ctl.grp = AGRP_ADD;
    unique case (opcode)
      OPC_RTYPE: begin
        ctl.dst_from_rd = 1'b1;
        ctl.rf_write    = 1'b1;
        ctl.grp         = AGRP_FUNCT;
      end
      OPC_LOAD: begin
        ctl.b_from_imm  = 1'b1;
        ctl.wb_from_mem = 1'b1;
        ctl.rf_write    = 1'b1;
        ctl.dm_read     = 1'b1;
      end
      OPC_STORE: begin
        ctl.b_from_imm = 1'b1;
        ctl.dm_write   = 1'b1;
      end
      OPC_BEQ: begin
        ctl.is_branch = 1'b1;
        ctl.grp       = AGRP_SUB;
      end
      OPC_JUMP: ctl.is_jump = 1'b1;
      default:  ctl = '0;
    endcase
  end

  always_comb begin
    unique case (ctl.grp)
      AGRP_ADD: alu_sel = ALU_ADD;
      AGRP_SUB: alu_sel = ALU_SUB;
      AGRP_FUNCT: begin
        unique case (funct)
          FN_ADD:  alu_sel = ALU_ADD;
          FN_SUB:  alu_sel = ALU_SUB;
          FN_AND:  alu_sel = ALU_AND;
          FN_OR:   alu_sel = ALU_OR;
          FN_SLT:  alu_sel = ALU_SLT;
          default: alu_sel = ALU_ADD;
        endcase
      end
      default: alu_sel = ALU_ADD;
    endcase
  end
endmodule

// File: rtl/scp_regfile.sv
module scp_regfile #(
  parameter int NREG = 32,
  parameter int W    = 32,
  localparam int RA_W = $clog2(NREG)
) (
  input  logic            clk,
  input  logic            we,
  input  logic [RA_W-1:0] waddr,
  input  logic [W-1:0]    wdata,
  input  logic [RA_W-1:0] ra_a,
  input  logic [RA_W-1:0] ra_b,
  input  logic [RA_W-1:0] ra_dbg,
  output logic [W-1:0]    rd_a,
  output logic [W-1:0]    rd_b,
  output logic [W-1:0]    rd_dbg
);
  logic [W-1:0] regs [NREG];

  assign regs[0] = '0;

  for (genvar g = 1; g < NREG; g++) begin : g_reg
    always_ff @(posedge clk) begin
      if (we && (waddr == RA_W'(g))) regs[g] <= wdata;
    end
  end

  assign rd_a   = regs[ra_a];
  assign rd_b   = regs[ra_b];
  assign rd_dbg = regs[ra_dbg];
endmodule

// File: rtl/scp_wordmem.sv
module scp_wordmem #(
  parameter int W   = 32,
  parameter int AW  = 6,
  parameter int NRD = 1,
  localparam int DEPTH = 2 ** AW
) (
  input  logic                    clk,
  input  logic                    we,
  input  logic [AW-1:0]           waddr,
  input  logic [W-1:0]            wdata,
  input  logic [NRD-1:0][AW-1:0]  raddr,
  output logic [NRD-1:0][W-1:0]   rdata
);
  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  for (genvar p = 0; p < NRD; p++) begin : g_rd
    assign rdata[p] = mem[raddr[p]];
  end
endmodule

// File: rtl/scp_core.sv
module scp_core
  import scp_pkg::*;
#(
  parameter int IMEM_AW = 6,
  parameter int DMEM_AW = 6,
  parameter int NREG    = 32,
  parameter int LD_AW   = (IMEM_AW > DMEM_AW) ? IMEM_AW : DMEM_AW,
  parameter int RSEL_W  = $clog2(NREG)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               ld_imem_we,
  input  logic               ld_dmem_we,
  input  logic [LD_AW-1:0]   ld_addr,
  input  logic [XLEN-1:0]    ld_data,
  input  logic [RSEL_W-1:0]  dbg_reg_sel,
  output logic [XLEN-1:0]    dbg_reg_val,
  input  logic [DMEM_AW-1:0] dbg_mem_addr,
  output logic [XLEN-1:0]    dbg_mem_val,
  output logic [XLEN-1:0]    pc_out
);
  logic [XLEN-1:0] pc_q, pc_d, pc_plus4, br_tgt, jmp_tgt;
  logic [XLEN-1:0] instr, imm_sx;
  logic [5:0]      opcode, funct;
  logic [RSEL_W-1:0] f_rs, f_rt, f_rd, rf_waddr;
  ctl_t            ctl;
  alu_sel_e        alu_sel;
  logic [XLEN-1:0] rs_val, rt_val, alu_b, alu_y, wb_val, dm_word, dm_load;
  logic            alu_zero, rf_we, dm_core_we;
  logic [0:0][XLEN-1:0]        imem_rd;
  logic [1:0][XLEN-1:0]        dmem_rd;
  logic                        dmem_we;
  logic [DMEM_AW-1:0]          dmem_waddr;
  logic [XLEN-1:0]             dmem_wdata;
  logic                        unused_bits;

  // Fetch
  scp_wordmem #(.W(XLEN), .AW(IMEM_AW), .NRD(1)) u_imem (
    .clk   (clk),
    .we    (rst & ld_imem_we),
    .waddr (ld_addr[IMEM_AW-1:0]),
    .wdata (ld_data),
    .raddr (pc_q[IMEM_AW+1:2]),
    .rdata (imem_rd)
  );
  assign instr = imem_rd[0];

  // Decode fields
  assign opcode = instr[31:26];
  assign funct  = instr[5:0];
  assign f_rs   = instr[25:21];
  assign f_rt   = instr[20:16];
  assign f_rd   = instr[15:11];
  assign imm_sx = {{16{instr[15]}}, instr[15:0]};

  scp_ctrl u_ctrl (
    .opcode  (opcode),
    .funct   (funct),
    .ctl     (ctl),
    .alu_sel (alu_sel)
  );

  // Register file
  assign rf_waddr = ctl.dst_from_rd ? f_rd : f_rt;
  assign rf_we    = ctl.rf_write & ~rst;

  scp_regfile #(.NREG(NREG), .W(XLEN)) u_rf (
    .clk    (clk),
    .we     (rf_we),
    .waddr  (rf_waddr),
    .wdata  (wb_val),
    .ra_a   (f_rs),
    .ra_b   (f_rt),
    .ra_dbg (dbg_reg_sel),
    .rd_a   (rs_val),
    .rd_b   (rt_val),
    .rd_dbg (dbg_reg_val)
  );

  // Execute
  assign alu_b = ctl.b_from_imm ? imm_sx : rt_val;

  scp_alu #(.W(XLEN)) u_alu (
    .sel  (alu_sel),
    .a    (rs_val),
    .b    (alu_b),
    .y    (alu_y),
    .zero (alu_zero)
  );

  // Data store: preload owns the write port during reset
  assign dm_core_we = ctl.dm_write & ~rst;
  assign dmem_we    = rst ? ld_dmem_we : dm_core_we;
  assign dmem_waddr = rst ? ld_addr[DMEM_AW-1:0] : alu_y[DMEM_AW+1:2];
  assign dmem_wdata = rst ? ld_data : rt_val;

  scp_wordmem #(.W(XLEN), .AW(DMEM_AW), .NRD(2)) u_dmem (
    .clk   (clk),
    .we    (dmem_we),
    .waddr (dmem_waddr),
    .wdata (dmem_wdata),
    .raddr ({dbg_mem_addr, alu_y[DMEM_AW+1:2]}),
    .rdata (dmem_rd)
  );
  assign dm_word     = dmem_rd[0];
  assign dbg_mem_val = dmem_rd[1];
  assign dm_load     = ctl.dm_read ? dm_word : '0;
  assign wb_val      = ctl.wb_from_mem ? dm_load : alu_y;

  // Next PC
  assign pc_plus4 = pc_q + 32'd4;
  assign br_tgt   = pc_plus4 + {imm_sx[XLEN-3:0], 2'b00};
  assign jmp_tgt  = {pc_plus4[31:28], instr[25:0], 2'b00};

  always_comb begin
    if (ctl.is_jump)                    pc_d = jmp_tgt;
    else if (ctl.is_branch && alu_zero) pc_d = br_tgt;
    else                                pc_d = pc_plus4;
  end

  always_ff @(posedge clk) begin
    if (rst) pc_q <= '0;
    else     pc_q <= pc_d;
  end

  assign pc_out = pc_q;

  assign unused_bits = ^{instr[10:6], pc_q[1:0], pc_q[XLEN-1:IMEM_AW+2],
                         alu_y[1:0], alu_y[XLEN-1:DMEM_AW+2]};
endmodule

// File: rtl/scp_core_chk.sv
module scp_core_chk
  import scp_pkg::*;
(
  input logic            clk,
  input logic            rst,
  input logic [XLEN-1:0] pc,
  input logic [XLEN-1:0] instr,
  input logic [XLEN-1:0] rs_val,
  input logic [XLEN-1:0] rt_val,
  input logic            rf_we,
  input logic [4:0]      rf_waddr,
  input logic            dm_we
);
  logic [5:0]      op;
  logic [XLEN-1:0] br_off;
  logic [XLEN-1:0] seq_pc;
  assign op     = instr[31:26];
  assign br_off = {{14{instr[15]}}, instr[15:0], 2'b00};
  assign seq_pc = pc + 32'd4;

  // R1
  a_r1_pc_reset: assert property (@(posedge clk) rst |=> (pc == '0));

  // R2
  a_r2_seq_pc: assert property (@(posedge clk) disable iff (rst)
    (op != OPC_BEQ && op != OPC_JUMP) |=> (pc == $past(pc) + 32'd4));

  // R3
  a_r3_load_dst: assert property (@(posedge clk) disable iff (rst)
    (op == OPC_LOAD) |-> (rf_we && rf_waddr == instr[20:16] && !dm_we));

  // R4
  a_r4_store_no_rf: assert property (@(posedge clk) disable iff (rst)
    (op == OPC_STORE) |-> (!rf_we && dm_we));

  // R5
  a_r5_rtype_dst: assert property (@(posedge clk) disable iff (rst)
    (op == OPC_RTYPE) |-> (rf_we && rf_waddr == instr[15:11]));

  // R7
  a_r7_beq_taken: assert property (@(posedge clk) disable iff (rst)
    (op == OPC_BEQ && rs_val == rt_val) |=> (pc == $past(seq_pc) + $past(br_off)));

  a_r7_beq_fall: assert property (@(posedge clk) disable iff (rst)
    (op == OPC_BEQ && rs_val != rt_val) |=> (pc == $past(seq_pc)));

  // R8
  a_r8_jump: assert property (@(posedge clk) disable iff (rst)
    (op == OPC_JUMP) |=> (pc == {$past(seq_pc[31:28]), $past(instr[25:0]), 2'b00}));

  // R9
  a_r9_zero_reg: assert property (@(posedge clk) disable iff (rst)
    (instr[25:21] == 5'd0) |-> (rs_val == '0));
endmodule

bind scp_core scp_core_chk chk_i (
  .clk      (clk),
  .rst      (rst),
  .pc       (pc_q),
  .instr    (instr),
  .rs_val   (rs_val),
  .rt_val   (rt_val),
  .rf_we    (rf_we),
  .rf_waddr (rf_waddr),
  .dm_we    (dm_core_we)
);

// File: tb/scp_core_tb_top.sv
module scp_core_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        ld_imem_we = 1'b0, ld_dmem_we = 1'b0;
  logic [5:0]  ld_addr = '0;
  logic [31:0] ld_data = '0;
  logic [4:0]  dbg_reg_sel = '0;
  logic [31:0] dbg_reg_val;
  logic [5:0]  dbg_mem_addr = '0;
  logic [31:0] dbg_mem_val;
  logic [31:0] pc_out;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  always #4 clk = ~clk;

  scp_core dut_i (
    .clk(clk), .rst(rst), .ld_imem_we(ld_imem_we), .ld_dmem_we(ld_dmem_we),
    .ld_addr(ld_addr), .ld_data(ld_data), .dbg_reg_sel(dbg_reg_sel),
    .dbg_reg_val(dbg_reg_val), .dbg_mem_addr(dbg_mem_addr),
    .dbg_mem_val(dbg_mem_val), .pc_out(pc_out)
  );

  function automatic logic [31:0] enc_r(int rs, int rt, int rd, logic [5:0] fn);
    return {6'h00, 5'(rs), 5'(rt), 5'(rd), 5'd0, fn};
  endfunction
  function automatic logic [31:0] enc_i(logic [5:0] op, int rs, int rt, int imm);
    return {op, 5'(rs), 5'(rt), 16'(imm)};
  endfunction
  function automatic logic [31:0] enc_j(int word_tgt);
    return {6'h02, 26'(word_tgt)};
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic put_i(input int a, input logic [31:0] w);
    @(negedge clk);
    ld_imem_we = 1'b1; ld_addr = 6'(a); ld_data = w;
    @(negedge clk);
    ld_imem_we = 1'b0;
  endtask

  task automatic put_d(input int a, input logic [31:0] w);
    @(negedge clk);
    ld_dmem_we = 1'b1; ld_addr = 6'(a); ld_data = w;
    @(negedge clk);
    ld_dmem_we = 1'b0;
  endtask

  task automatic get_reg(input int r, output logic [31:0] v);
    dbg_reg_sel = 5'(r);
    #1 v = dbg_reg_val;
  endtask

  task automatic get_mem(input int a, output logic [31:0] v);
    dbg_mem_addr = 6'(a);
    #1 v = dbg_mem_val;
  endtask

  task automatic enter_reset();
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
  endtask

  task automatic leave_reset();
    @(negedge clk);
    rst = 1'b0;
  endtask

  // R1: held reset keeps PC at 0 and blocks the store at word 0
  task automatic t_reset();
    logic [31:0] v;
    enter_reset();
    put_d(6, 32'hAAAA_5555);
    put_i(0, enc_i(6'h2B, 0, 0, 24));   // sw r0,24(r0)
    repeat (5) @(negedge clk);
    chk("R1 pc in reset", pc_out, 32'h0);
    get_mem(6, v);
    chk("R1 no store during reset", v, 32'hAAAA_5555);
  endtask

  // R3 R4 R5 R6 R9 R11: straight-line arithmetic and memory program
  task automatic t_alu_mem();
    logic [31:0] v;
    enter_reset();
    put_d(0, 32'h0000_0007);
    put_d(1, 32'h0000_0005);
    put_d(2, 32'hFFFF_FFFD);
    put_i(0,  enc_i(6'h23, 0, 1, 0));
    put_i(1,  enc_i(6'h23, 0, 2, 4));
    put_i(2,  enc_i(6'h23, 0, 3, 8));
    put_i(3,  enc_r(1, 2, 4, 6'h20));
    put_i(4,  enc_r(2, 1, 5, 6'h22));
    put_i(5,  enc_r(1, 2, 6, 6'h24));
    put_i(6,  enc_r(1, 3, 7, 6'h25));
    put_i(7,  enc_r(3, 1, 8, 6'h2A));
    put_i(8,  enc_r(1, 3, 9, 6'h2A));
    put_i(9,  enc_i(6'h2B, 0, 4, 16));
    put_i(10, enc_r(1, 2, 0, 6'h20));
    put_i(11, enc_i(6'h23, 4, 10, -4));
    put_i(12, enc_r(1, 0, 31, 6'h20));
    put_i(13, enc_i(6'h2B, 4, 5, -8));  // offset bits [15:11] name r31
    put_i(14, enc_j(14));
    leave_reset();
    repeat (20) @(negedge clk);
    get_reg(1, v);  chk("R3 lw r1", v, 32'h7);
    get_reg(3, v);  chk("R3 lw r3", v, 32'hFFFF_FFFD);
    get_reg(4, v);  chk("R5 add", v, 32'd12);
    get_reg(5, v);  chk("R5 sub", v, 32'hFFFF_FFFE);
    get_reg(6, v);  chk("R5 and", v, 32'h5);
    get_reg(7, v);  chk("R5 or", v, 32'hFFFF_FFFF);
    get_reg(8, v);  chk("R6 slt signed true", v, 32'h1);
    get_reg(9, v);  chk("R6 slt signed false", v, 32'h0);
    get_reg(0, v);  chk("R9 r0 stays zero", v, 32'h0);
    get_reg(10, v); chk("R3 negative offset load", v, 32'hFFFF_FFFD);
    get_reg(31, v); chk("R4 store writes no register", v, 32'h7);
    get_mem(4, v);  chk("R4 sw word 4", v, 32'd12);
    get_mem(1, v);  chk("R4 sw negative offset", v, 32'hFFFF_FFFE);
    get_mem(0, v);  chk("R11 dbg mem read", v, 32'h7);
    chk("R2 halt pc", pc_out, 32'd56);
  endtask

  // R2 R7 R8: PC trace through branches and jumps
  task automatic t_flow();
    logic [31:0] v;
    logic [31:0] exp_pc [9] = '{32'd4, 32'd8, 32'd20, 32'd24, 32'd28,
                                 32'd40, 32'd44, 32'd36, 32'd36};
    enter_reset();
    put_d(0, 32'h0000_0007);
    put_d(1, 32'h0000_0005);
    put_i(0,  enc_i(6'h23, 0, 1, 0));
    put_i(1,  enc_i(6'h23, 0, 2, 0));
    put_i(2,  enc_i(6'h04, 1, 2, 2));
    put_i(3,  enc_r(1, 1, 10, 6'h20));
    put_i(4,  enc_r(1, 1, 10, 6'h20));
    put_i(5,  enc_i(6'h23, 0, 3, 4));
    put_i(6,  enc_i(6'h04, 1, 3, 5));
    put_i(7,  enc_j(10));
    put_i(8,  enc_r(1, 1, 31, 6'h20));
    put_i(9,  enc_j(9));
    put_i(10, enc_r(1, 3, 22, 6'h20));
    put_i(11, enc_j(9));
    leave_reset();
    chk("R1 pc at release", pc_out, 32'h0);
    for (int i = 0; i < 9; i++) begin
      @(negedge clk);
      chk($sformatf("R2 R7 R8 pc step %0d", i + 1), pc_out, exp_pc[i]);
    end
    get_reg(10, v); chk("R7 skipped by taken beq", v, 32'hFFFF_FFFD);
    get_reg(31, v); chk("R8 skipped by jump", v, 32'h7);
    get_reg(22, v); chk("R8 jump target executed", v, 32'd12);
  endtask

  // R10: preload strobes ignored while running
  task automatic t_preload_blocked();
    logic [31:0] v;
    put_d(6, 32'h1111_2222);
    put_i(9, enc_j(0));
    repeat (4) @(negedge clk);
    get_mem(6, v);
    chk("R10 dmem preload ignored", v, 32'hAAAA_5555);
    chk("R10 imem preload ignored", pc_out, 32'd36);
  endtask

  initial begin
    t_reset();
    t_alu_mem();
    t_flow();
    t_preload_blocked();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule